// File: doc/BRIEF.md
# Single-Cycle Control Word Decoder

This block turns one 16-bit instruction of a small eight-register processor into the 20-bit control word that steers a single-cycle datapath. The word carries three register-file addresses, a four-bit function select, the operand-multiplexer select, the result-multiplexer select, the register and memory write enables, and three program-counter controls. The instruction holds a 7-bit opcode in bits [15:9], a destination field in [8:6], a first-source field in [5:3] and a second-source or small-constant field in [2:0].

The three high opcode bits sort each instruction into a class. The opcodes are assigned so that every control bit is a function of only one or two opcode bits. The program-counter controls reuse opcode bit 13 as the jump/branch select and opcode bit 9 as the branch condition. For branches, bit 9 is masked out of the function select so that the select reads zero.

An instruction is presented with a valid strobe. The control word comes out of a register one clock later, with its own valid flag. When no new instruction arrives, the last word is held.

Top module: `ctl_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, `cw_valid` and every bit of `ctrl_word` go to 0.
- R2: An instruction presented with `instr_valid`=1 at a rising edge appears decoded on `ctrl_word`, with `cw_valid`=1, right after that edge. After an edge with `instr_valid`=0, `cw_valid` is 0 and `ctrl_word` keeps its previous value.
- R3: Register addresses pass straight through: `ctrl_word[19:17]` = instr[8:6], `ctrl_word[16:14]` = instr[5:3], `ctrl_word[13:11]` = instr[2:0].
- R4: Control bits by class instr[15:13], given as the four bits MB (`ctrl_word[10]`), MD (`[5]`), RW (`[4]`) and MW (`[3]`):
  - 000 (register ALU op) gives MB=0, MD=0, RW=1, MW=0.
  - 001 (memory load) gives MB=0, MD=1, RW=1, MW=0.
  - 100 (ALU op with constant) gives MB=1, MD=0, RW=1, MW=0.
  - 101 gives MB=1, MD=1, RW=1, MW=0.
- R5: Class 010 (memory store) gives MB=0, MD=0, RW=0, MW=1. Class 011 gives MB=0, MD=1, RW=0, MW=1. RW and MW are never both 1.
- R6: When instr[15:14]=11 (program-counter control), PL (`ctrl_word[2]`) is 1 and RW=0, MW=0. Class 110 also gives MB=1, MD=0, and class 111 gives MB=1, MD=1. In every other class PL is 0.
- R7: JB (`ctrl_word[1]`) always equals instr[13]: 0 selects branch, 1 selects jump. BC (`ctrl_word[0]`) always equals instr[9]: 0 branches on zero, 1 branches on negative.
- R8: FS (`ctrl_word[9:6]`) equals instr[12:9] when PL=0. When PL=1 it equals {instr[12:10], 0}, so a branch with opcode 1100000 or 1100001 yields FS=0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies `instr` for this cycle |
| instr | input | 16 | Instruction to decode |
| cw_valid | output | 1 | Control word was loaded at the last edge |
| ctrl_word | output | 20 | Decoded control word, fields as in R3 to R8 |

## Verification
There is no state beyond the output register, so a wrong decode shows on `ctrl_word` at the first edge after the offending instruction is presented. A stale or wrongly loaded output register shows up as a changed word during idle cycles or as a mismatched `cw_valid`, also within one cycle. The decoder is checked field by field against expectations derived from the class rules. It is driven with every listed opcode and with every class, using random register fields. A wrongly gated function-select bit appears only on instructions with PL=1, so branches with both condition values are included.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
  localparam int INSTR_W  = 16;
  localparam int RA_W     = 3;
  localparam int FS_W     = 4;
  localparam int NUM_RF   = 3;
  localparam int OPC_LSB  = NUM_RF * RA_W;
  localparam int OPC_W    = INSTR_W - OPC_LSB;
  localparam int CLS_W    = 3;
  localparam int CLS_LSB  = INSTR_W - CLS_W;
  localparam int FS_LSB   = OPC_LSB;
  localparam int CW_W     = NUM_RF * RA_W + FS_W + 7;

  typedef struct packed {
    logic [RA_W-1:0] da;
    logic [RA_W-1:0] aa;
    logic [RA_W-1:0] ba;
    logic            mb;
    logic [FS_W-1:0] fs;
    logic            md;
    logic            rw;
    logic            mw;
    logic            pl;
    logic            jb;
    logic            bc;
  } ctl_word_t;
endpackage

// File: rtl/ctl_addr_route.sv
module ctl_addr_route
  import ctl_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [RA_W-1:0]    da,
  output logic [RA_W-1:0]    aa,
  output logic [RA_W-1:0]    ba
);
  logic [RA_W-1:0] fld [NUM_RF];

  // Slice the low instruction bits into equal register fields, lowest first.
  for (genvar g = 0; g < NUM_RF; g++) begin : g_fld
    assign fld[g] = instr[g*RA_W +: RA_W];
  end

  assign ba = fld[0];
  assign aa = fld[1];
  assign da = fld[2];
endmodule

// File: rtl/ctl_class_logic.sv
module ctl_class_logic
  import ctl_dec_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             cond_sel,
  output logic             mb,
  output logic             md,
  output logic             rw,
  output logic             mw,
  output logic             pl,
  output logic             jb,
  output logic             bc
);
  logic top_b, mid_b, low_b;

  assign {top_b, mid_b, low_b} = cls;

  // Opcode assignment keeps each control bit to one or two class bits.
  always_comb begin
    mb = top_b;
    md = low_b;
    rw = ~mid_b;
    mw = mid_b & ~top_b;
    pl = top_b & mid_b;
    jb = low_b;
    bc = cond_sel;
  end
endmodule

// File: rtl/ctl_fs_mask.sv
module ctl_fs_mask
  import ctl_dec_pkg::*;
(
  input  logic [FS_W-1:0] fs_raw,
  input  logic            pl,
  output logic [FS_W-1:0] fs
);
  // The lowest select bit doubles as the branch condition; blank it on PC-control.
  assign fs = {fs_raw[FS_W-1:1], fs_raw[0] & ~pl};
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_dec_pkg::*;
#(
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic               cw_valid,
  output logic [CW_W-1:0]    ctrl_word
);
  ctl_word_t cw_next;

  ctl_addr_route u_addr (
    .instr (instr),
    .da    (cw_next.da),
    .aa    (cw_next.aa),
    .ba    (cw_next.ba)
  );

  ctl_class_logic u_cls (
    .cls      (instr[CLS_LSB +: CLS_W]),
    .cond_sel (instr[FS_LSB]),
    .mb       (cw_next.mb),
    .md       (cw_next.md),
    .rw       (cw_next.rw),
    .mw       (cw_next.mw),
    .pl       (cw_next.pl),
    .jb       (cw_next.jb),
    .bc       (cw_next.bc)
  );

  ctl_fs_mask u_fs (
    .fs_raw (instr[FS_LSB +: FS_W]),
    .pl     (cw_next.pl),
    .fs     (cw_next.fs)
  );

  if (REGISTER_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        cw_valid  <= 1'b0;
        ctrl_word <= '0;
      end else begin
        cw_valid <= instr_valid;
        if (instr_valid) ctrl_word <= cw_next;
      end
    end
  end else begin : g_comb
    assign cw_valid  = instr_valid;
    assign ctrl_word = cw_next;
  end
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk
  import ctl_dec_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               cw_valid,
  input logic [CW_W-1:0]    ctrl_word
);
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> cw_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!cw_valid && $stable(ctrl_word)));

  a_r3_addr_pass: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> (ctrl_word[CW_W-1 -: NUM_RF*RA_W] == $past(instr[NUM_RF*RA_W-1:0])));

  a_r5_no_dual_write: assert property (@(posedge clk) disable iff (rst)
    cw_valid |-> !(ctrl_word[4] && ctrl_word[3]));

  a_r6_pc_no_write: assert property (@(posedge clk) disable iff (rst)
    (cw_valid && ctrl_word[2]) |-> (!ctrl_word[4] && !ctrl_word[3]));

  a_r8_branch_fs_zero: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[15:9] == 7'b1100001) |=> (ctrl_word[9:6] == 4'b0000 && ctrl_word[2]));
endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .cw_valid    (cw_valid),
  .ctrl_word   (ctrl_word)
);

// File: tb/ctl_decoder_test.sv
module ctl_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        cw_valid;
  logic [19:0] ctrl_word;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;
  logic [19:0] sb_q[$];
  logic [19:0] last_word = '0;

  always #10 clk = ~clk;

  ctl_decoder uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .cw_valid(cw_valid), .ctrl_word(ctrl_word)
  );

  // Expected word from the class rules of the requirements.
  function automatic logic [19:0] expect_word(logic [15:0] i);
    logic mb, md, rw, mw, pl;
    logic [3:0] fs;
    case (i[15:13])
      3'b000: {mb, md, rw, mw, pl} = 5'b00100;   // R4
      3'b001: {mb, md, rw, mw, pl} = 5'b01100;   // R4
      3'b010: {mb, md, rw, mw, pl} = 5'b00010;   // R5
      3'b011: {mb, md, rw, mw, pl} = 5'b01010;   // R5
      3'b100: {mb, md, rw, mw, pl} = 5'b10100;   // R4
      3'b101: {mb, md, rw, mw, pl} = 5'b11100;   // R4
      3'b110: {mb, md, rw, mw, pl} = 5'b10001;   // R6
      default: {mb, md, rw, mw, pl} = 5'b11001;  // R6
    endcase
    fs = pl ? {i[12:10], 1'b0} : i[12:9];        // R8
    return {i[8:0], mb, fs, md, rw, mw, pl, i[13], i[9]};  // R3, R7
  endfunction

  function automatic string cls_req(logic [19:0] w);
    if (w[2]) return "R6";
    if (w[3]) return "R5";
    return "R4";
  endfunction

  task automatic check(bit ok, string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] i);
    instr       = i;
    instr_valid = 1'b1;
    sb_q.push_back(expect_word(i));
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic send_op(logic [6:0] op);
    send({op, 9'($urandom)});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      instr = 16'($urandom);
      @(negedge clk);
    end
  endtask

  // Monitor: pop the scoreboard as words appear, compare field groups.
  always @(negedge clk) begin
    if (mon_en) begin
      if (cw_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", ctrl_word, '0);
        end else begin
          logic [19:0] e;
          e = sb_q.pop_front();
          check(ctrl_word[19:11] == e[19:11], "R3", ctrl_word, e);
          check({ctrl_word[10], ctrl_word[5:2]} == {e[10], e[5:2]}, cls_req(e), ctrl_word, e);
          check(ctrl_word[1:0] == e[1:0], "R7", ctrl_word, e);
          check(ctrl_word[9:6] == e[9:6], "R8", ctrl_word, e);
          last_word = e;
        end
      end else begin
        check(ctrl_word == last_word, "R2", ctrl_word, last_word);
      end
    end
  end

  localparam logic [6:0] OPS [20] = '{
    7'b0000000, 7'b0000001, 7'b0000010, 7'b0000101, 7'b0000110,
    7'b0001000, 7'b0001001, 7'b0001010, 7'b0001011, 7'b0001100,
    7'b0001101, 7'b0001110, 7'b1001100, 7'b1000010, 7'b0010000,
    7'b0100000, 7'b1100000, 7'b1100001, 7'b1110000, 7'b1110001
  };

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check(cw_valid == 1'b0, "R1", {19'd0, cw_valid}, '0);
    check(ctrl_word == '0, "R1", ctrl_word, '0);
    rst = 1'b0;
    mon_en = 1'b1;
    // Named examples: ADI gives MB=1 FS=0010 RW=1 (R4); BRZ gives PL=1 JB=0 BC=0 (R6, R7)
    send(16'b1000010_010_111_011);
    send(16'b1100000_101_110_100);
    idle(2);
    // Every listed opcode, random register fields, back-to-back and with gaps
    for (int r = 0; r < 6; r++) begin
      foreach (OPS[j]) begin
        send_op(OPS[j]);
        if ((j + r) % 3 == 0) idle(1);
      end
    end
    // Every opcode value, covering all classes and both condition bits (R5, R6, R8)
    for (int op = 0; op < 128; op++) send_op(7'(op));
    idle(3);
    // Reset mid-stream clears the output (R1)
    send_op(7'b0001110);
    mon_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(cw_valid == 1'b0 && ctrl_word == '0, "R1", ctrl_word, '0);
    sb_q.delete();
    last_word = '0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule